// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration image into a device that accepts its image over a slave-serial port. That port has three lines driven by this block: a program strobe (active low), a configuration clock and a serial data line. It also has two status lines returned to the block: an init line, which reads high once the device is ready to accept data, and a done line, which reads high once the device has finished loading.

A single-cycle start pulse launches a load of `byte_count_i` bytes. The block first holds program low for a fixed interval and then releases it. Next it polls init for a bounded number of cycles. Each byte it accepts on a valid/ready stream is shifted out, most significant bit first, one bit per configuration clock period. After the data phase it keeps pulsing the configuration clock until done reads high. If the byte source flags an error, the data phase ends early and the block moves on to the finishing clock phase.

The outcome is a single-cycle success pulse or a single-cycle error pulse, with an error kind. A busy flag spans the whole run. The init and done inputs pass through a two-stage synchronizer. All timings are parameters counted in system clock cycles.

Top module: `cfgl_loader`

## Requirements
- R1: Out of reset, and whenever busy is low, program is high and the configuration clock, data, busy and byte_ready are all low.
- R2: A start pulse taken while idle drives program low for exactly PROG_HOLD cycles, then returns it high. Program is low exactly once per run, and the configuration clock stays low while program is low.
- R3: After program is released, the block waits for the synchronized init input to read high. If init has not read high after INIT_POLLS polls, the run ends with an error pulse and err_kind 0, PROG_HOLD+INIT_POLLS cycles after the start. In that case no clock pulse is issued and no byte is requested.
- R4: Each byte is sent bit 7 first and bit 0 last. The data line is set HALF_PERIOD cycles before each rising clock edge and does not change while the clock is high. The clock stays high for HALF_PERIOD cycles.
- R5: byte_ready rises exactly once for each byte requested, and exactly byte_count_i bytes are requested. byte_ready is high only while busy, with program high and the clock low.
- R6: A handshake with byte_err_i high discards that byte and ends the data phase at once. No bit of it is sent, no further byte is requested, and the finishing phase follows.
- R7: After the data phase, the block issues clock pulses until the synchronized done input reads high, then gives a success pulse with no error pulse.
- R8: If done is still low after DONE_POLLS finishing pulses, the block issues no more pulses and gives an error pulse with err_kind 1.
- R9: A byte count of 0 skips the data phase. If done is already high, the run succeeds with no clock pulse at all.
- R10: Success and error never occur in the same cycle. Each lasts one cycle and coincides with busy falling. Busy rises in the cycle after the start pulse is taken. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (taken only while idle) |
| byte_count_i | input | COUNT_W | Number of bytes to send, sampled with start |
| byte_valid_i | input | 1 | Byte source offers a byte |
| byte_data_i | input | 8 | Offered byte |
| byte_err_i | input | 1 | Byte source failed; ends the data phase |
| byte_ready_o | output | 1 | Block accepts the offered byte this cycle |
| prog_n_o | output | 1 | Program strobe, active low |
| cclk_o | output | 1 | Configuration clock |
| cdata_o | output | 1 | Serial configuration data |
| init_n_i | input | 1 | Init status, high when the device is ready (asynchronous) |
| done_i | input | 1 | Done status, high when loading is complete (asynchronous) |
| busy_o | output | 1 | High from the start until the result pulse |
| success_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | One-cycle error pulse |
| err_kind_o | output | 1 | Error kind: 0 init timeout, 1 done timeout; valid with error_o |

## Verification
A wrong bit index or a wrong shift shows within one byte, as a wrong serial pattern captured at the rising clock edges. A wrong byte counter shows as an extra or missing rise of byte_ready, or as a total count of clock edges that differs from eight per byte plus the finishing pulses. A poll counter with an off-by-one limit moves the error pulse by a cycle, or adds or drops one finishing pulse, and both are counted exactly at the ports. A state that leaks out of the run leaves program, clock or data away from their idle levels once busy has dropped.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TAIL_CHK,
        ST_TAIL_HI,
        ST_TAIL_LO
    } cfgl_state_e;

    localparam logic ERR_INIT_TIMEOUT = 1'b0;
    localparam logic ERR_DONE_TIMEOUT = 1'b1;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] value_i,
    output logic             zero_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - WIDTH'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader #(
    parameter int PROG_HOLD   = 64,
    parameter int HALF_PERIOD = 3,
    parameter int INIT_POLLS  = 100000,
    parameter int DONE_POLLS  = 100000,
    parameter int COUNT_W     = 24
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [COUNT_W-1:0] byte_count_i,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_data_i,
    input  logic               byte_err_i,
    output logic               byte_ready_o,
    output logic               prog_n_o,
    output logic               cclk_o,
    output logic               cdata_o,
    input  logic               init_n_i,
    input  logic               done_i,
    output logic               busy_o,
    output logic               success_o,
    output logic               error_o,
    output logic               err_kind_o
);
    import cfgl_pkg::*;

    localparam int TMR_MAX  = (PROG_HOLD > HALF_PERIOD) ? PROG_HOLD : HALF_PERIOD;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int POLL_MAX = (INIT_POLLS > DONE_POLLS) ? INIT_POLLS : DONE_POLLS;
    localparam int POLL_W   = $clog2(POLL_MAX + 1);

    localparam logic [TMR_W-1:0]  HOLD_LOAD = TMR_W'(PROG_HOLD - 1);
    localparam logic [TMR_W-1:0]  HALF_LOAD = TMR_W'(HALF_PERIOD - 1);
    localparam logic [POLL_W-1:0] INIT_LAST = POLL_W'(INIT_POLLS - 1);
    localparam logic [POLL_W-1:0] DONE_LIM  = POLL_W'(DONE_POLLS);

    typedef struct packed {
        cfgl_state_e          state;
        logic                 prog_n;
        logic                 cclk;
        logic [7:0]           shreg;
        logic [2:0]           bit_idx;
        logic [COUNT_W-1:0]   remain;
        logic [POLL_W-1:0]    polls;
        logic                 busy;
        logic                 success;
        logic                 error;
        logic                 err_kind;
    } regs_t;

    regs_t            d, q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_value;
    logic             tmr_zero;
    logic [1:0]       stat_sync;
    logic             init_rdy;
    logic             done_rdy;

    cfgl_sync #(.WIDTH(2)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({done_i, init_n_i}),
        .sync_o  (stat_sync)
    );
    assign init_rdy = stat_sync[0];
    assign done_rdy = stat_sync[1];

    cfgl_timer #(.WIDTH(TMR_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tmr_load),
        .value_i (tmr_value),
        .zero_o  (tmr_zero)
    );

    always_comb begin
        d         = q;
        d.success = 1'b0;
        d.error   = 1'b0;
        tmr_load  = 1'b0;
        tmr_value = '0;

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state   = ST_PROG;
                    d.prog_n  = 1'b0;
                    d.busy    = 1'b1;
                    d.remain  = byte_count_i;
                    tmr_load  = 1'b1;
                    tmr_value = HOLD_LOAD;
                end
            end
            ST_PROG: begin
                if (tmr_zero) begin
                    d.prog_n = 1'b1;
                    d.polls  = '0;
                    d.state  = ST_WAIT_INIT;
                end
            end
            ST_WAIT_INIT: begin
                if (init_rdy) begin
                    d.state = ST_FETCH;
                end else if (q.polls == INIT_LAST) begin
                    d.state    = ST_IDLE;
                    d.busy     = 1'b0;
                    d.error    = 1'b1;
                    d.err_kind = ERR_INIT_TIMEOUT;
                    d.shreg    = '0;
                end else begin
                    d.polls = q.polls + POLL_W'(1);
                end
            end
            ST_FETCH: begin
                if (q.remain == '0) begin
                    d.state = ST_TAIL_CHK;
                    d.polls = '0;
                end else if (byte_valid_i) begin
                    if (byte_err_i) begin
                        d.state = ST_TAIL_CHK;
                        d.polls = '0;
                    end else begin
                        d.shreg   = byte_data_i;
                        d.bit_idx = 3'd7;
                        d.remain  = q.remain - COUNT_W'(1);
                        d.state   = ST_BIT_LO;
                        tmr_load  = 1'b1;
                        tmr_value = HALF_LOAD;
                    end
                end
            end
            ST_BIT_LO: begin
                if (tmr_zero) begin
                    d.cclk    = 1'b1;
                    d.state   = ST_BIT_HI;
                    tmr_load  = 1'b1;
                    tmr_value = HALF_LOAD;
                end
            end
            ST_BIT_HI: begin
                if (tmr_zero) begin
                    d.cclk = 1'b0;
                    if (q.bit_idx == 3'd0) begin
                        d.state = ST_FETCH;
                    end else begin
                        d.bit_idx = q.bit_idx - 3'd1;
                        d.shreg   = {q.shreg[6:0], 1'b0};
                        d.state   = ST_BIT_LO;
                        tmr_load  = 1'b1;
                        tmr_value = HALF_LOAD;
                    end
                end
            end
            ST_TAIL_CHK: begin
                if (done_rdy) begin
                    d.state   = ST_IDLE;
                    d.busy    = 1'b0;
                    d.success = 1'b1;
                    d.shreg   = '0;
                end else if (q.polls == DONE_LIM) begin
                    d.state    = ST_IDLE;
                    d.busy     = 1'b0;
                    d.error    = 1'b1;
                    d.err_kind = ERR_DONE_TIMEOUT;
                    d.shreg    = '0;
                end else begin
                    d.polls   = q.polls + POLL_W'(1);
                    d.cclk    = 1'b1;
                    d.state   = ST_TAIL_HI;
                    tmr_load  = 1'b1;
                    tmr_value = HALF_LOAD;
                end
            end
            ST_TAIL_HI: begin
                if (tmr_zero) begin
                    d.cclk    = 1'b0;
                    d.state   = ST_TAIL_LO;
                    tmr_load  = 1'b1;
                    tmr_value = HALF_LOAD;
                end
            end
            ST_TAIL_LO: begin
                if (tmr_zero) begin
                    d.state = ST_TAIL_CHK;
                end
            end
            default: begin
                d.state  = ST_IDLE;
                d.busy   = 1'b0;
                d.prog_n = 1'b1;
                d.cclk   = 1'b0;
                d.shreg  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.prog_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_ready_o = (q.state == ST_FETCH) && (q.remain != '0);
    assign prog_n_o     = q.prog_n;
    assign cclk_o       = q.cclk;
    assign cdata_o      = q.shreg[7];
    assign busy_o       = q.busy;
    assign success_o    = q.success;
    assign error_o      = q.error;
    assign err_kind_o   = q.err_kind;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
    parameter int HOLD = 64
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic byte_ready_o,
    input logic prog_n_o,
    input logic cclk_o,
    input logic cdata_o,
    input logic busy_o,
    input logic success_o,
    input logic error_o
);
    localparam int LOW_W = $clog2(HOLD + 2);

    logic [LOW_W-1:0] low_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        low_cnt_q <= '0;
        else if (prog_n_o)  low_cnt_q <= '0;
        else if (low_cnt_q <= LOW_W'(HOLD)) low_cnt_q <= low_cnt_q + LOW_W'(1);
    end

    assert_idle_levels_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (prog_n_o && !cclk_o && !cdata_o && !byte_ready_o));

    assert_prog_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_cnt_q <= LOW_W'(HOLD));

    assert_no_clk_in_prog_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !prog_n_o |-> !cclk_o);

    assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cclk_o |-> $stable(cdata_o));

    assert_ready_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_ready_o |-> (busy_o && prog_n_o && !cclk_o));

    assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(success_o && error_o));

    assert_result_ends_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (success_o || error_o) |-> (!busy_o && $past(busy_o)));

    assert_busy_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (success_o || error_o));

    assert_start_taken_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && !prog_n_o));
endmodule

bind cfgl_loader cfgl_checker #(.HOLD(PROG_HOLD)) u_cfgl_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .byte_ready_o (byte_ready_o),
    .prog_n_o     (prog_n_o),
    .cclk_o       (cclk_o),
    .cdata_o      (cdata_o),
    .busy_o       (busy_o),
    .success_o    (success_o),
    .error_o      (error_o)
);

// File: tb/test_cfgl_loader.sv
`timescale 1ns/1ps
module test_cfgl_loader;
    localparam int HOLD  = 6;
    localparam int HALF  = 2;
    localparam int IPOLL = 20;
    localparam int DPOLL = 10;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] count = '0;
    logic          bvalid = 1'b0;
    logic [7:0]    bdata = '0;
    logic          berr = 1'b0;
    logic          bready, prog_n, cclk, cdata, busy, succ, err, ekind;
    logic          init_drv = 1'b0;
    logic          done_drv = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // knobs written only by the stimulus process
    int init_delay  = 4;
    int done_target = 1000000;

    // observations written only by the monitor
    int   rises = 0, ready_rises = 0, prog_runs = 0, last_low = 0, low_run = 0;
    int   high_since = 0, hi_len = 0, last_hi_len = 0, n_succ = 0, n_err = 0;
    int   busy_len = 0, last_busy_len = 0;
    logic last_kind = 1'b0;
    logic prev_cclk = 1'b0, prev_ready = 1'b0, prev_busy = 1'b0;
    logic bits [0:1023];

    always #10 clk = ~clk;

    cfgl_loader #(
        .PROG_HOLD(HOLD), .HALF_PERIOD(HALF), .INIT_POLLS(IPOLL),
        .DONE_POLLS(DPOLL), .COUNT_W(CW)
    ) i_cfgl_loader (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_count_i(count),
        .byte_valid_i(bvalid), .byte_data_i(bdata), .byte_err_i(berr),
        .byte_ready_o(bready), .prog_n_o(prog_n), .cclk_o(cclk), .cdata_o(cdata),
        .init_n_i(init_drv), .done_i(done_drv), .busy_o(busy),
        .success_o(succ), .error_o(err), .err_kind_o(ekind)
    );

    always @(negedge clk) begin
        if (cclk && !prev_cclk) begin
            if (rises < 1024) bits[rises] = cdata;
            rises++;
        end
        if (cclk) hi_len++;
        else if (prev_cclk) begin last_hi_len = hi_len; hi_len = 0; end
        if (bready && !prev_ready) ready_rises++;
        if (!prog_n) begin
            if (low_run == 0) prog_runs++;
            low_run++;
            high_since = 0;
        end else begin
            if (low_run != 0) last_low = low_run;
            low_run = 0;
            high_since++;
        end
        if (busy) busy_len++;
        else if (prev_busy) begin last_busy_len = busy_len; busy_len = 0; end
        if (succ) n_succ++;
        if (err) begin n_err++; last_kind = ekind; end
        init_drv   = prog_n && (high_since >= init_delay);
        done_drv   = (rises >= done_target);
        prev_cclk  = cclk;
        prev_ready = bready;
        prev_busy  = busy;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #2;
    endtask

    // one load: bytes from pat, byte at err_at flagged as failed (-1 none)
    task automatic run_load(input int n, input logic [7:0] pat [0:7], input int err_at,
                            input int idelay, input int done_extra, input bit restart);
        int guard;
        init_delay  = idelay;
        done_target = (done_extra < 0) ? 1000000 : rises + 8 * ((err_at >= 0 && err_at < n) ? err_at : n) + done_extra;
        count = CW'(n);
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R10", "busy after start", int'(busy), 1);
        for (int i = 0; i < n; i++) begin
            bvalid = 1'b1;
            bdata  = pat[i];
            berr   = (i == err_at);
            guard  = 0;
            while (!bready && busy && guard < 5000) begin step(); guard++; end
            if (!busy) break;
            step();
            bvalid = 1'b0;
            berr   = 1'b0;
            if (restart && i == 0) begin start = 1'b1; step(); start = 1'b0; end
            if (i == err_at) break;
        end
        bvalid = 1'b0;
        berr   = 1'b0;
        guard  = 0;
        while (busy && guard < 20000) begin step(); guard++; end
        chk("R10", "run finished", int'(busy), 0);
        step();
        chk("R1", "idle levels {prog,cclk,data,busy,ready}",
            int'({prog_n, cclk, cdata, busy, bready}), 5'b10000);
    endtask

    task automatic t_reset();
        chk("R1", "reset levels {prog,cclk,data,busy,ready}",
            int'({prog_n, cclk, cdata, busy, bready}), 5'b10000);
        chk("R1", "no result pulse in reset", int'({succ, err}), 0);
    endtask

    task automatic t_normal();
        logic [7:0] p [0:7] = '{8'hA5, 8'h3C, 8'h81, 0, 0, 0, 0, 0};
        int r0 = rises, q0 = ready_rises, g0 = prog_runs, s0 = n_succ, e0 = n_err;
        run_load(3, p, -1, 4, 3, 1'b1);
        chk("R2", "program low length", last_low, HOLD);
        chk("R2", "single program pulse despite second start", prog_runs - g0, 1);
        for (int b = 0; b < 3; b++) begin
            int v = 0;
            for (int k = 0; k < 8; k++) v = (v << 1) | int'(bits[r0 + 8 * b + k]);
            chk("R4", "byte shifted MSB first", v, int'(p[b]));
        end
        chk("R4", "clock high length", last_hi_len, HALF);
        chk("R5", "bytes requested", ready_rises - q0, 3);
        chk("R7", "clock edges data plus finish", rises - r0, 27);
        chk("R7", "success pulses", n_succ - s0, 1);
        chk("R10", "no error pulse", n_err - e0, 0);
    endtask

    task automatic t_init_timeout();
        logic [7:0] p [0:7] = '{8'hFF, 8'hFF, 0, 0, 0, 0, 0, 0};
        int r0 = rises, q0 = ready_rises, e0 = n_err, s0 = n_succ;
        run_load(2, p, -1, 100000, 0, 1'b0);
        chk("R3", "error pulses", n_err - e0, 1);
        chk("R3", "error kind init", int'(last_kind), 0);
        chk("R3", "no clock pulse", rises - r0, 0);
        chk("R3", "no byte requested", ready_rises - q0, 0);
        chk("R3", "busy length", last_busy_len, HOLD + IPOLL);
        chk("R10", "no success pulse", n_succ - s0, 0);
    endtask

    task automatic t_done_timeout();
        logic [7:0] p [0:7] = '{8'h5A, 0, 0, 0, 0, 0, 0, 0};
        int r0 = rises, e0 = n_err, s0 = n_succ;
        run_load(1, p, -1, 3, -1, 1'b0);
        chk("R8", "clock edges byte plus limit", rises - r0, 8 + DPOLL);
        chk("R8", "error pulses", n_err - e0, 1);
        chk("R8", "error kind done", int'(last_kind), 1);
        chk("R8", "no success pulse", n_succ - s0, 0);
    endtask

    task automatic t_source_error();
        logic [7:0] p [0:7] = '{8'hC3, 8'h99, 8'h11, 8'h22, 0, 0, 0, 0};
        int r0 = rises, q0 = ready_rises, s0 = n_succ, v = 0;
        run_load(4, p, 1, 5, 2, 1'b0);
        for (int k = 0; k < 8; k++) v = (v << 1) | int'(bits[r0 + k]);
        chk("R6", "first byte intact", v, 8'hC3);
        chk("R6", "clock edges first byte plus finish", rises - r0, 10);
        chk("R6", "requests stop after failed byte", ready_rises - q0, 2);
        chk("R6", "success after finish", n_succ - s0, 1);
    endtask

    task automatic t_zero_count();
        logic [7:0] p [0:7] = '{0, 0, 0, 0, 0, 0, 0, 0};
        int r0 = rises, q0 = ready_rises, s0 = n_succ;
        run_load(0, p, -1, 2, 0, 1'b0);
        chk("R9", "no clock pulse", rises - r0, 0);
        chk("R9", "no byte requested", ready_rises - q0, 0);
        chk("R9", "success", n_succ - s0, 1);
        r0 = rises;
        s0 = n_succ;
        run_load(0, p, -1, 2, 1, 1'b0);
        chk("R9", "one finishing pulse when done late", rises - r0, 1);
        chk("R9", "success after late done", n_succ - s0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) step();
        t_reset();
        rst_n = 1'b1;
        repeat (3) step();
        t_reset();
        t_normal();
        t_init_timeout();
        t_done_timeout();
        t_source_error();
        t_zero_count();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule